// File: doc/BRIEF.md
# Programmable countdown interval timer

This block counts down a loaded value using a two-level scheme. An inner sub-counter advances on one of several timebase strobes. Each time it wraps, an outer count register drops by one. When the outer count reaches zero, the timer sets a sticky status bit and can pull an active-low interrupt line. Software drives the block through plain register inputs: reload value, sub-count, timebase select, enable, single/periodic mode, interrupt-line enable, start trigger (immediate or alarm) and a status-clear strobe. The current outer count can be read back at all times.

In single mode the timer halts at zero. Clearing status starts a new run. In periodic mode the count reloads at zero. The interrupt line is low for one sub-count period and then high for the rest of the period, so the first period's high time is longer than later ones. In alarm-start mode, an alarm strobe launches the countdown. Alarms that arrive while the timer is counting are ignored.

Top module: `intv_timer`

## Requirements
- R1: A rising edge of `en_i` copies `reload_i` into `count_o` on the next cycle. If `reload_i` is below 2 at that point, no countdown starts, and none starts until `en_i` is dropped and raised again with a valid value.
- R2: While running, `count_o` falls by exactly one for every S selected ticks, where S is `subcnt_i`. A `subcnt_i` of 0 means S = 1.
- R3: `src_sel_i` = k picks `tick_i[k]` (code 0 is the slowest input). Strobes on the other tick inputs leave `count_o` unchanged.
- R4: The tick that brings the count to zero sets `stat_o` on the next cycle. `stat_o` then stays 1 until a `stat_clr_i` pulse.
- R5: At expiry `irq_no` goes low only if `irq_en_i` is 1, and `irq_no` is never low while `stat_o` is 0.
- R6: Single mode: after expiry `count_o` stays 0 and ticks have no effect. A status clear sets `irq_no` high, reloads `count_o` and restarts counting.
- R7: Periodic mode: `count_o` reloads at expiry and counting continues. `irq_no` returns high after S more ticks, and the next expiry comes after reload×S ticks in total.
- R8: Periodic mode: a status clear while running reloads `count_o` and starts a fresh first period.
- R9: Alarm-start mode: enabling loads the count but does not start it. An `alarm_i` pulse starts the countdown, and alarms while running are ignored. After a single-mode expiry the timer waits for a new alarm.
- R10: If a status clear and an expiry fall in the same cycle, `stat_o` ends up 1.
- R11: `en_i` = 0 stops counting, sets `irq_no` high and leaves `stat_o` as it was.
- R12: After reset `stat_o` = 0, `irq_no` = 1 and `count_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 4 | Timebase strobes, index 0 slowest |
| src_sel_i | input | 2 | Timebase select |
| reload_i | input | 8 | Outer count reload value |
| subcnt_i | input | 8 | Ticks per outer decrement, 0 = default |
| en_i | input | 1 | Timer enable |
| periodic_i | input | 1 | 1 = periodic, 0 = single |
| irq_en_i | input | 1 | Allow interrupt line to assert |
| alarm_mode_i | input | 1 | 1 = start on alarm strobe |
| alarm_i | input | 1 | Alarm event strobe |
| stat_clr_i | input | 1 | Status-clear strobe |
| stat_o | output | 1 | Sticky expiry status |
| irq_no | output | 1 | Active-low interrupt line |
| count_o | output | 8 | Current outer count |

## Verification
A status clear and an expiry can land in the same cycle. The clear asks for a fresh restart and the expiry asks to set the status bit. The bench schedules the clear pulse on the very tick that takes a periodic count from one to zero. It then checks that status stays set and the line goes low. A second overlap, an alarm strobe during a run, is checked by confirming that the count keeps its value rather than reloading.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } tmr_state_e;

  localparam int unsigned MIN_RELOAD = 2;
endpackage

// File: rtl/intv_tick_sel.sv
module intv_tick_sel #(
  parameter  int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] & (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/intv_prescale.sv
module intv_prescale #(
  parameter int unsigned W       = 8,
  parameter int unsigned DEF_SUB = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] sub_i,
  output logic         ovf_o
);
  logic [W-1:0] sub_q;
  logic [W-1:0] lim;

  assign lim   = (sub_i == '0) ? W'(DEF_SUB) : sub_i;
  // >= keeps the wrap alive if the limit is lowered mid-count
  assign ovf_o = run_i & tick_i & (sub_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sub_q <= W'(1);
    else if (restart_i || !run_i) sub_q <= W'(1);
    else if (ovf_o)              sub_q <= W'(1);
    else if (tick_i)             sub_q <= sub_q + W'(1);
  end
endmodule

// File: rtl/intv_ctrl.sv
module intv_ctrl
  import intv_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         periodic_i,
  input  logic         irq_en_i,
  input  logic         alarm_mode_i,
  input  logic         alarm_i,
  input  logic         stat_clr_i,
  input  logic [W-1:0] reload_i,
  input  logic         ovf_i,
  output logic         run_o,
  output logic         restart_o,
  output logic         expire_o,
  output logic         stat_o,
  output logic         irq_low_o,
  output logic [W-1:0] count_o
);
  tmr_state_e   state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         stat_q, stat_d;
  logic         irq_q, irq_d;
  logic         en_q;
  logic         en_rise, reload_ok, clr_hit, expire, load;

  assign en_rise   = en_i & ~en_q;
  assign reload_ok = reload_i >= W'(MIN_RELOAD);
  assign clr_hit   = stat_clr_i & stat_q;
  assign run_o     = (state_q == ST_RUN);
  assign expire    = run_o & ovf_i & (cnt_q == W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stat_d  = stat_q;
    irq_d   = irq_q;
    load    = 1'b0;
    if (clr_hit) begin
      stat_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (!en_i) begin
      state_d = ST_IDLE;
      irq_d   = 1'b0;
    end else if (en_rise) begin
      cnt_d = reload_i;
      if (alarm_mode_i) state_d = ST_ARMED;
      else if (reload_ok) begin
        state_d = ST_RUN;
        load    = 1'b1;
      end else state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ARMED: begin
          if (alarm_i && reload_ok) begin
            state_d = ST_RUN;
            cnt_d   = reload_i;
            load    = 1'b1;
          end
        end
        ST_RUN: begin
          if (expire) begin
            // expiry outranks a same-cycle clear
            stat_d = 1'b1;
            irq_d  = irq_en_i;
            if (periodic_i) begin
              cnt_d = reload_i;
              if (!reload_ok) state_d = ST_IDLE;
            end else begin
              cnt_d   = '0;
              state_d = alarm_mode_i ? ST_ARMED : ST_DONE;
            end
          end else if (clr_hit) begin
            cnt_d = reload_i;
            load  = 1'b1;
            if (!reload_ok) state_d = ST_IDLE;
          end else if (ovf_i) begin
            cnt_d = cnt_q - W'(1);
            irq_d = 1'b0;
          end
        end
        ST_DONE: begin
          if (clr_hit) begin
            if (alarm_mode_i) state_d = ST_ARMED;
            else if (reload_ok) begin
              state_d = ST_RUN;
              cnt_d   = reload_i;
              load    = 1'b1;
            end else state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stat_q  <= 1'b0;
      irq_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      irq_q   <= irq_d;
      en_q    <= en_i;
    end
  end

  assign restart_o = load;
  assign expire_o  = expire;
  assign stat_o    = stat_q;
  assign irq_low_o = irq_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/intv_timer.sv
module intv_timer #(
  parameter  int unsigned CNT_W   = 8,
  parameter  int unsigned N_SRC   = 4,
  parameter  int unsigned DEF_SUB = 1,
  localparam int unsigned SEL_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] subcnt_i,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             irq_en_i,
  input  logic             alarm_mode_i,
  input  logic             alarm_i,
  input  logic             stat_clr_i,
  output logic             stat_o,
  output logic             irq_no,
  output logic [CNT_W-1:0] count_o
);
  logic tick, run, restart, ovf, expire, irq_low;

  intv_tick_sel #(.N_SRC(N_SRC)) i_tick_sel (
    .tick_i (tick_i),
    .sel_i  (src_sel_i),
    .tick_o (tick)
  );

  intv_prescale #(.W(CNT_W), .DEF_SUB(DEF_SUB)) i_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .tick_i    (tick),
    .sub_i     (subcnt_i),
    .ovf_o     (ovf)
  );

  intv_ctrl #(.W(CNT_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .periodic_i   (periodic_i),
    .irq_en_i     (irq_en_i),
    .alarm_mode_i (alarm_mode_i),
    .alarm_i      (alarm_i),
    .stat_clr_i   (stat_clr_i),
    .reload_i     (reload_i),
    .ovf_i        (ovf),
    .run_o        (run),
    .restart_o    (restart),
    .expire_o     (expire),
    .stat_o       (stat_o),
    .irq_low_o    (irq_low),
    .count_o      (count_o)
  );

  assign irq_no = ~irq_low;
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             stat_clr_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             stat_o,
  input logic             irq_no,
  input logic             expire
);
  assert_irq_needs_stat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> stat_o);

  assert_stat_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !stat_clr_i) |=> stat_o);

  assert_expire_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> stat_o);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      (count_o == $past(count_o) - CNT_W'(1) || count_o == $past(reload_i)));

  assert_disable_releases_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> irq_no);
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .stat_clr_i (stat_clr_i),
  .reload_i   (reload_i),
  .count_o    (count_o),
  .stat_o     (stat_o),
  .irq_no     (irq_no),
  .expire     (expire)
);

// File: tb/test_intv_timer.sv
module test_intv_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick = '0;
  logic [1:0] sel = '0;
  logic [7:0] reload = '0, subv = '0;
  logic       en = 0, per = 0, irq_en = 0, alm_mode = 0, alarm = 0, clr = 0;
  logic       stat_o, irq_no;
  logic [7:0] count_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intv_timer i_intv_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .src_sel_i(sel),
    .reload_i(reload), .subcnt_i(subv), .en_i(en), .periodic_i(per),
    .irq_en_i(irq_en), .alarm_mode_i(alm_mode), .alarm_i(alarm),
    .stat_clr_i(clr), .stat_o(stat_o), .irq_no(irq_no), .count_o(count_o)
  );

  // behavioural reference: 0 idle, 1 armed, 2 running, 3 halted
  int m_st, m_cnt, m_sub, m_stat, m_irq, m_enq;
  always @(posedge clk or negedge rst_n) begin : model
    int lim, n_st, n_cnt, n_stat, n_irq;
    bit tk, okr, run, ovf, fin, clrh, ld;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sub = 1; m_stat = 0; m_irq = 0; m_enq = 0;
    end else begin
      tk = tick[sel]; lim = (subv == 0) ? 1 : int'(subv);
      okr = reload >= 2; run = (m_st == 2);
      ovf = run && tk && (m_sub >= lim);
      fin = ovf && (m_cnt == 1);
      clrh = clr && (m_stat == 1);
      n_st = m_st; n_cnt = m_cnt; n_stat = m_stat; n_irq = m_irq; ld = 0;
      if (clrh) begin n_stat = 0; n_irq = 0; end
      if (!en) begin n_st = 0; n_irq = 0; end
      else if (m_enq == 0) begin
        n_cnt = reload;
        if (alm_mode) n_st = 1; else if (okr) begin n_st = 2; ld = 1; end else n_st = 0;
      end else if (m_st == 1) begin
        if (alarm && okr) begin n_st = 2; n_cnt = reload; ld = 1; end
      end else if (m_st == 2) begin
        if (fin) begin
          n_stat = 1; n_irq = irq_en;
          if (per) begin n_cnt = reload; if (!okr) n_st = 0; end
          else begin n_cnt = 0; n_st = alm_mode ? 1 : 3; end
        end else if (clrh) begin
          n_cnt = reload; ld = 1; if (!okr) n_st = 0;
        end else if (ovf) begin n_cnt = m_cnt - 1; n_irq = 0; end
      end else if (m_st == 3) begin
        if (clrh) begin
          if (alm_mode) n_st = 1;
          else if (okr) begin n_st = 2; n_cnt = reload; ld = 1; end
          else n_st = 0;
        end
      end
      if (ld || !run) m_sub = 1; else if (ovf) m_sub = 1; else if (tk) m_sub = m_sub + 1;
      m_st = n_st; m_cnt = n_cnt; m_stat = n_stat; m_irq = n_irq; m_enq = en;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 count vs model", int'(count_o), m_cnt);
    chk("R4 stat vs model", int'(stat_o), m_stat);
    chk("R5 irq vs model", int'(irq_no), m_irq ? 0 : 1);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic tk(input int idx);
    tick[idx] = 1'b1; step(); tick = '0; step();
  endtask
  task automatic tks(input int idx, input int n);
    for (int i = 0; i < n; i++) tk(idx);
  endtask
  task automatic pclr();
    clr = 1; step(); clr = 0; step();
  endtask
  task automatic palarm();
    alarm = 1; step(); alarm = 0; step();
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R12 reset stat", stat_o, 0);
    chk("R12 reset irq", irq_no, 1);
    chk("R12 reset count", count_o, 0);
    rst_n = 1; step();

    // single mode, R=3 S=2 on tick 1
    sel = 1; reload = 3; subv = 2; irq_en = 1; en = 1; step();
    chk("R1 load on enable", count_o, 3);
    tks(0, 3); tks(2, 2);
    chk("R3 unselected ticks ignored", count_o, 3);
    tks(1, 5);
    chk("R2 count after 5 ticks", count_o, 1);
    chk("R4 no stat before expiry", stat_o, 0);
    tk(1);
    chk("R4 stat at expiry", stat_o, 1);
    chk("R5 irq low at expiry", irq_no, 0);
    tks(1, 3);
    chk("R6 halted at zero", count_o, 0);
    pclr();
    chk("R6 clear restarts count", count_o, 3);
    chk("R6 clear releases irq", irq_no, 1);
    chk("R6 clear drops stat", stat_o, 0);

    // default sub-count, irq disabled
    en = 0; step();
    subv = 0; reload = 2; irq_en = 0; en = 1; step();
    tk(1);
    chk("R2 default sub-count", count_o, 1);
    tk(1);
    chk("R5 stat without irq", stat_o, 1);
    chk("R5 irq masked", irq_no, 1);
    pclr();

    // invalid reload
    en = 0; step(); reload = 1; en = 1; step();
    chk("R1 small reload loaded", count_o, 1);
    tks(1, 3);
    chk("R1 small reload no run", count_o, 1);
    chk("R1 small reload no stat", stat_o, 0);

    // periodic R=3 S=2 on tick 2
    en = 0; step(); reload = 3; subv = 2; irq_en = 1; per = 1; sel = 2; en = 1; step();
    tks(1, 2);
    chk("R3 old source ignored", count_o, 3);
    tks(2, 6);
    chk("R7 first expiry stat", stat_o, 1);
    chk("R7 first expiry irq", irq_no, 0);
    chk("R7 reload at expiry", count_o, 3);
    tk(2);
    chk("R7 irq low within S", irq_no, 0);
    tk(2);
    chk("R7 irq high after S", irq_no, 1);
    chk("R7 stat held", stat_o, 1);
    tks(2, 4);
    chk("R7 second expiry irq", irq_no, 0);
    chk("R7 second expiry count", count_o, 3);
    tk(2);
    pclr();
    chk("R8 clear reloads", count_o, 3);
    chk("R8 clear drops stat", stat_o, 0);
    tks(2, 5);
    chk("R8 fresh full period", stat_o, 0);
    tk(2);
    chk("R8 expiry after full period", stat_o, 1);
    tks(2, 5);
    chk("R10 pre count", count_o, 1);
    tick[2] = 1; clr = 1; step(); tick = '0; clr = 0; step();
    chk("R10 clear with expiry keeps stat", stat_o, 1);
    chk("R10 irq low", irq_no, 0);

    // disable mid low phase
    en = 0; step();
    chk("R11 irq released", irq_no, 1);
    chk("R11 stat kept", stat_o, 1);
    tks(2, 3);
    chk("R11 count frozen", count_o, 3);
    pclr();

    // alarm start, single, R=2 S=1 on tick 0
    alm_mode = 1; per = 0; reload = 2; subv = 1; sel = 0; en = 1; step();
    tks(0, 2);
    chk("R9 armed holds", count_o, 2);
    palarm();
    tk(0);
    chk("R9 runs after alarm", count_o, 1);
    palarm();
    chk("R9 alarm ignored while running", count_o, 1);
    tk(0);
    chk("R9 expiry", stat_o, 1);
    pclr();
    tks(0, 2);
    chk("R9 waits for alarm", count_o, 0);
    palarm();
    chk("R9 alarm reloads", count_o, 2);
    tk(0);
    chk("R9 rerun", count_o, 1);

    step(); step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule